// File: doc/BRIEF.md
# Two-Cell Battery Protection Controller

This block is the decision core of a protector for a pack of two lithium cells in series. It takes comparator results that have already been digitised and turns them into two gate commands: one that allows charging and one that allows discharging. The comparator results cover each cell against the high and low voltage limits, the current-sense node against two overcurrent levels, a charger-present level and a near-supply level, and the whole pack against a near-zero level. A slow time-base strobe sets all detection delays. Each delay is counted in strobes, and each fault must hold without a break for its full delay before it takes effect.

The controller has six states. START is the state after reset, with discharge blocked. NORMAL enables both switches. OVERCHG blocks charge. OVERDSG blocks discharge. PWRDN blocks discharge and asks the rest of the chip to power down. OVERCUR blocks discharge after excess current. Each state has its own way out, and each way out depends on the cell and sense flags. A static configuration input decides whether a pack near zero volts may be charged.

The transitions are: START to NORMAL (sense node low or charger seen); NORMAL to OVERCUR, OVERDSG or OVERCHG (qualified faults, in that priority); OVERCHG to NORMAL (release level reached, or load seen); OVERDSG to PWRDN (sense node near supply); OVERDSG to NORMAL (release level reached, or detection level reached with a charger present); PWRDN to OVERDSG (sense node leaves supply); OVERCUR to NORMAL (sense node back below level 1); OVERCUR to PWRDN (current persists and a cell is low).

Top module: `batt_guard_ctrl`

## Requirements
- R1: After reset the mode code is 0 (START), discharge-enable is 0, charge-enable is 1 and power-down request is 0. START moves to NORMAL on the first clock edge at which the sense node is below overcurrent level 1 or a charger is seen. Otherwise it stays in START.
- R2: In NORMAL (mode code 1) both enables are 1 and power-down is 0. When more than one fault qualifies on the same edge, overcurrent wins over overdischarge, and overdischarge wins over overcharge.
- R3: A fault condition is counted only while the block is in NORMAL. Its counter goes up by one on each edge that has the strobe high, and it stops at the fault's limit. Any edge without the condition clears the counter. The state changes on the first edge at which the counter already stands at the limit and the condition is still present. For overcharge, the condition is that any cell is above its overcharge level and the limit is OVC_TICKS. The target is OVERCHG (mode code 2), with charge-enable 0 and discharge-enable 1.
- R4: OVERCHG returns to NORMAL when no cell is above the overcharge release level and no charger is seen.
- R5: OVERCHG also returns to NORMAL when every cell is below the overcharge detection level, the sense node is at or above overcurrent level 1, and no charger is seen.
- R6: While a charger is seen, OVERCHG holds, whatever the cell voltages are.
- R7: If any cell is below the overdischarge level for OVD_TICKS strobes (counted as in R3), the block enters OVERDSG (mode code 3), with charge-enable 1 and discharge-enable 0.
- R8: In OVERDSG, a sense node near the supply moves the block to PWRDN (mode code 4), with power-down request 1, discharge-enable 0 and charge-enable 1. PWRDN goes back to OVERDSG on the first edge at which the sense node is no longer near the supply.
- R9: OVERDSG returns to NORMAL once no cell is below the overdischarge release level. While a charger is seen, it is enough that no cell is below the overdischarge detection level.
- R10: If the sense node is at or above overcurrent level 1 for OC1_TICKS strobes (counted as in R3), the block enters OVERCUR (mode code 5), with discharge-enable 0 and charge-enable 1. OVERCUR returns to NORMAL on the first edge at which the sense node is below level 1.
- R11: The level-2 delay starts counting at the same time as the level-1 condition and has the limit OC2_TICKS. Once that delay has expired, the sense node at or above level 2 trips OVERCUR.
- R12: Overcurrent is neither counted nor tripped while any cell is above its overcharge detection level.
- R13: In OVERCUR, the edges with the strobe high are counted from entry. Once OVD_TICKS have passed and any cell is below the overdischarge level, the block moves to PWRDN.
- R14: When zero-volt charging is not allowed and the pack is below the zero-volt inhibit level, charge-enable is 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_tick | input | 1 | Delay time-base strobe |
| cell_above_ovc | input | NUM_CELLS | Per cell: above the overcharge detection level |
| cell_above_ovc_rel | input | NUM_CELLS | Per cell: above the overcharge release level |
| cell_below_ovd | input | NUM_CELLS | Per cell: below the overdischarge detection level |
| cell_below_ovd_rel | input | NUM_CELLS | Per cell: below the overdischarge release level |
| sense_ge_oc1 | input | 1 | Sense node at or above overcurrent level 1 |
| sense_ge_oc2 | input | 1 | Sense node at or above overcurrent level 2 |
| sense_chg_seen | input | 1 | Sense node below the charger-detect level |
| sense_near_supply | input | 1 | Sense node within the power-down margin of the positive supply |
| pack_below_zinh | input | 1 | Pack voltage below the zero-volt inhibit level |
| zero_chg_allow | input | 1 | Static option: charging a near-zero pack is allowed |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| pwr_down_req | output | 1 | Power-down request |
| mode_code | output | 3 | Current state code |

## Verification
The bench builds the block with two cells, an overcharge limit of 4 strobes, an overdischarge limit of 6, an overcurrent level-1 limit of 3 and a level-2 limit of 1. With limits this short, every delay expires within a few cycles, so each fault path, each release path and the OVERCUR to PWRDN path can be walked many times in one short run. Because the level-2 limit is below the level-1 limit, a level-2 trip shows up one edge or more before a level-1 trip would, which tells the two apart. A phase with the strobe running at half rate checks that only strobed edges advance a delay.

// File: rtl/batt_guard_pkg.sv
`timescale 1ns/1ps
package batt_guard_pkg;

    typedef enum logic [2:0] {
        BG_START   = 3'd0,
        BG_NORMAL  = 3'd1,
        BG_OVERCHG = 3'd2,
        BG_OVERDSG = 3'd3,
        BG_PWRDN   = 3'd4,
        BG_OVERCUR = 3'd5
    } bg_state_e;

    typedef struct packed {
        logic any_hi_det;
        logic any_hi_rel;
        logic any_lo_det;
        logic any_lo_rel;
    } bg_cell_sum_t;

endpackage

// File: rtl/bg_cell_reduce.sv
`timescale 1ns/1ps
module bg_cell_reduce
    import batt_guard_pkg::*;
#(
    parameter int NUM_CELLS = 2
) (
    input  logic [NUM_CELLS-1:0] hi_det,
    input  logic [NUM_CELLS-1:0] hi_rel,
    input  logic [NUM_CELLS-1:0] lo_det,
    input  logic [NUM_CELLS-1:0] lo_rel,
    output bg_cell_sum_t         summary
);
    localparam int FLAG_W = $bits(bg_cell_sum_t);

    logic [NUM_CELLS-1:0][FLAG_W-1:0] per_cell;
    logic [FLAG_W-1:0]                merged;

    // one flag group per cell, ordered as the summary struct
    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
        assign per_cell[gi] = {hi_det[gi], hi_rel[gi], lo_det[gi], lo_rel[gi]};
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_CELLS; i++) begin
            merged = merged | per_cell[i];
        end
    end

    assign summary = bg_cell_sum_t'(merged);

endmodule

// File: rtl/bg_persist_timer.sv
`timescale 1ns/1ps
module bg_persist_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic expired
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // strobed count of an unbroken condition, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM_V)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q == LIM_V);

    // R3: a counter never jumps by more than one step per edge
    assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && $past(cond) && cnt_q != '0) |-> (cnt_q - $past(cnt_q) <= CW'(1)));

endmodule

// File: rtl/batt_guard_ctrl.sv
`timescale 1ns/1ps
module batt_guard_ctrl
    import batt_guard_pkg::*;
#(
    parameter int NUM_CELLS = 2,
    parameter int OVC_TICKS = 4025,
    parameter int OVD_TICKS = 504,
    parameter int OC1_TICKS = 32,
    parameter int OC2_TICKS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dly_tick,
    input  logic [NUM_CELLS-1:0] cell_above_ovc,
    input  logic [NUM_CELLS-1:0] cell_above_ovc_rel,
    input  logic [NUM_CELLS-1:0] cell_below_ovd,
    input  logic [NUM_CELLS-1:0] cell_below_ovd_rel,
    input  logic                 sense_ge_oc1,
    input  logic                 sense_ge_oc2,
    input  logic                 sense_chg_seen,
    input  logic                 sense_near_supply,
    input  logic                 pack_below_zinh,
    input  logic                 zero_chg_allow,
    output logic                 chg_en,
    output logic                 dsg_en,
    output logic                 pwr_down_req,
    output logic [2:0]           mode_code
);
    bg_state_e    state_q, state_d;
    bg_cell_sum_t cs;

    logic ovc_cond, ovd_cond, oc_cond, pd_cond;
    logic ovc_exp, ovd_exp, oc1_exp, oc2_exp, pd_exp;
    logic trip_ovc, trip_ovd, trip_oc;
    logic chg_raw, zero_block;

    bg_cell_reduce #(.NUM_CELLS(NUM_CELLS)) u_reduce (
        .hi_det  (cell_above_ovc),
        .hi_rel  (cell_above_ovc_rel),
        .lo_det  (cell_below_ovd),
        .lo_rel  (cell_below_ovd_rel),
        .summary (cs)
    );

    // fault qualification: only counted from the normal state
    assign ovc_cond = (state_q == BG_NORMAL) && cs.any_hi_det;
    assign ovd_cond = (state_q == BG_NORMAL) && cs.any_lo_det;
    assign oc_cond  = (state_q == BG_NORMAL) && sense_ge_oc1 && !cs.any_hi_det;
    assign pd_cond  = (state_q == BG_OVERCUR);

    bg_persist_timer #(.LIMIT(OVC_TICKS)) u_ovc_tmr (
        .clk(clk), .rst_n(rst_n), .tick(dly_tick), .cond(ovc_cond), .expired(ovc_exp));
    bg_persist_timer #(.LIMIT(OVD_TICKS)) u_ovd_tmr (
        .clk(clk), .rst_n(rst_n), .tick(dly_tick), .cond(ovd_cond), .expired(ovd_exp));
    bg_persist_timer #(.LIMIT(OC1_TICKS)) u_oc1_tmr (
        .clk(clk), .rst_n(rst_n), .tick(dly_tick), .cond(oc_cond), .expired(oc1_exp));
    bg_persist_timer #(.LIMIT(OC2_TICKS)) u_oc2_tmr (
        .clk(clk), .rst_n(rst_n), .tick(dly_tick), .cond(oc_cond), .expired(oc2_exp));
    bg_persist_timer #(.LIMIT(OVD_TICKS)) u_pd_tmr (
        .clk(clk), .rst_n(rst_n), .tick(dly_tick), .cond(pd_cond), .expired(pd_exp));

    assign trip_oc  = oc_cond && (oc1_exp || (oc2_exp && sense_ge_oc2));
    assign trip_ovd = ovd_cond && ovd_exp;
    assign trip_ovc = ovc_cond && ovc_exp;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BG_START;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BG_START: begin
                if (sense_chg_seen || !sense_ge_oc1) state_d = BG_NORMAL;
            end
            BG_NORMAL: begin
                if (trip_oc)       state_d = BG_OVERCUR;
                else if (trip_ovd) state_d = BG_OVERDSG;
                else if (trip_ovc) state_d = BG_OVERCHG;
            end
            BG_OVERCHG: begin
                if (!sense_chg_seen &&
                    (!cs.any_hi_rel || (!cs.any_hi_det && sense_ge_oc1)))
                    state_d = BG_NORMAL;
            end
            BG_OVERDSG: begin
                if (sense_near_supply)
                    state_d = BG_PWRDN;
                else if (sense_chg_seen ? !cs.any_lo_det : !cs.any_lo_rel)
                    state_d = BG_NORMAL;
            end
            BG_PWRDN: begin
                if (!sense_near_supply) state_d = BG_OVERDSG;
            end
            BG_OVERCUR: begin
                if (!sense_ge_oc1)                state_d = BG_NORMAL;
                else if (pd_exp && cs.any_lo_det) state_d = BG_PWRDN;
            end
            default: state_d = BG_START;
        endcase
    end

    // outputs
    always_comb begin
        chg_raw      = 1'b1;
        dsg_en       = 1'b0;
        pwr_down_req = 1'b0;
        unique case (state_q)
            BG_START:   begin chg_raw = 1'b1; dsg_en = 1'b0; end
            BG_NORMAL:  begin chg_raw = 1'b1; dsg_en = 1'b1; end
            BG_OVERCHG: begin chg_raw = 1'b0; dsg_en = 1'b1; end
            BG_OVERDSG: begin chg_raw = 1'b1; dsg_en = 1'b0; end
            BG_PWRDN:   begin chg_raw = 1'b1; dsg_en = 1'b0; pwr_down_req = 1'b1; end
            BG_OVERCUR: begin chg_raw = 1'b1; dsg_en = 1'b0; end
            default:    begin chg_raw = 1'b0; dsg_en = 1'b0; end
        endcase
    end

    assign zero_block = !zero_chg_allow && pack_below_zinh;
    assign chg_en     = chg_raw && !zero_block;
    assign mode_code  = state_q;

    // R6: a present charger keeps the overcharge state
    assert_chg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_OVERCHG && sense_chg_seen) |=> (state_q == BG_OVERCHG));

    // R12: no overcurrent entry while a cell is above the overcharge level
    assert_oc_inhibit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_NORMAL && cs.any_hi_det) |=> (state_q != BG_OVERCUR));

    // R10: overcurrent clears once the sense node drops below level 1
    assert_oc_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_OVERCUR && !sense_ge_oc1) |=> (state_q == BG_NORMAL));

    // R7: overdischarge is entered from normal only with a low cell
    assert_ovd_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_OVERDSG && $past(state_q) == BG_NORMAL) |-> $past(cs.any_lo_det));

    // R8: power-down is reached only from overdischarge or overcurrent
    assert_pd_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_PWRDN && $past(state_q) != BG_PWRDN) |->
        ($past(state_q) == BG_OVERDSG || $past(state_q) == BG_OVERCUR));

    // R14: charge stays off for a near-zero pack when not allowed
    assert_zero_inh_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_chg_allow && pack_below_zinh) |-> !chg_en);

endmodule

// File: tb/batt_guard_ctrl_bench.sv
`timescale 1ns/1ps
module batt_guard_ctrl_bench;

    localparam int NC   = 2;
    localparam int L_OVC = 4;
    localparam int L_OVD = 6;
    localparam int L_OC1 = 3;
    localparam int L_OC2 = 1;

    // analog-style stimulus in millivolts, turned into flags below
    localparam int HI_DET = 4300;
    localparam int HI_REL = 4100;
    localparam int LO_DET = 2300;
    localparam int LO_REL = 3000;
    localparam int OC1_MV = 200;
    localparam int OC2_MV = 1200;
    localparam int CHG_MV = -700;
    localparam int PD_MARGIN = 1300;
    localparam int ZINH_MV = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic slow_tick = 1'b0;
    logic zero_allow = 1'b0;
    int   cell0_mv = 3700;
    int   cell1_mv = 3700;
    int   sense_mv = 0;

    logic [NC-1:0] f_hi_det, f_hi_rel, f_lo_det, f_lo_rel;
    logic f_oc1, f_oc2, f_chg, f_near, f_zinh;
    logic chg_en, dsg_en, pwr_down_req;
    logic [2:0] mode_code;

    assign f_hi_det = {cell1_mv > HI_DET, cell0_mv > HI_DET};
    assign f_hi_rel = {cell1_mv > HI_REL, cell0_mv > HI_REL};
    assign f_lo_det = {cell1_mv < LO_DET, cell0_mv < LO_DET};
    assign f_lo_rel = {cell1_mv < LO_REL, cell0_mv < LO_REL};
    assign f_oc1  = sense_mv >= OC1_MV;
    assign f_oc2  = sense_mv >= OC2_MV;
    assign f_chg  = sense_mv < CHG_MV;
    assign f_near = sense_mv >= (cell0_mv + cell1_mv - PD_MARGIN);
    assign f_zinh = (cell0_mv + cell1_mv) < ZINH_MV;

    batt_guard_ctrl #(
        .NUM_CELLS(NC), .OVC_TICKS(L_OVC), .OVD_TICKS(L_OVD),
        .OC1_TICKS(L_OC1), .OC2_TICKS(L_OC2)
    ) u_batt_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .dly_tick(tick),
        .cell_above_ovc(f_hi_det), .cell_above_ovc_rel(f_hi_rel),
        .cell_below_ovd(f_lo_det), .cell_below_ovd_rel(f_lo_rel),
        .sense_ge_oc1(f_oc1), .sense_ge_oc2(f_oc2), .sense_chg_seen(f_chg),
        .sense_near_supply(f_near), .pack_below_zinh(f_zinh),
        .zero_chg_allow(zero_allow),
        .chg_en(chg_en), .dsg_en(dsg_en), .pwr_down_req(pwr_down_req),
        .mode_code(mode_code)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    logic chk_on = 1'b0;

    // behavioural reference: state number plus one persistence count per delay
    int m_state = 0;
    int c_ovc = 0, c_ovd = 0, c_oc1 = 0, c_oc2 = 0, c_pd = 0;

    function automatic int bump(input bit cnd, input bit tk, input int c, input int lim);
        if (!cnd) return 0;
        if (tk && c < lim) return c + 1;
        return c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0;
            c_ovc = 0; c_ovd = 0; c_oc1 = 0; c_oc2 = 0; c_pd = 0;
        end else begin
            bit any_hi, any_hr, any_lo, any_lr, k_ovc, k_ovd, k_oc, k_pd;
            int nxt;
            any_hi = |f_hi_det; any_hr = |f_hi_rel;
            any_lo = |f_lo_det; any_lr = |f_lo_rel;
            k_ovc = (m_state == 1) && any_hi;
            k_ovd = (m_state == 1) && any_lo;
            k_oc  = (m_state == 1) && f_oc1 && !any_hi;
            k_pd  = (m_state == 5);
            nxt = m_state;
            case (m_state)
                0: if (f_chg || !f_oc1) nxt = 1;
                1: begin
                    if (k_oc && (c_oc1 == L_OC1 || (c_oc2 == L_OC2 && f_oc2))) nxt = 5;
                    else if (k_ovd && c_ovd == L_OVD) nxt = 3;
                    else if (k_ovc && c_ovc == L_OVC) nxt = 2;
                end
                2: if (!f_chg && (!any_hr || (!any_hi && f_oc1))) nxt = 1;
                3: begin
                    if (f_near) nxt = 4;
                    else if (f_chg ? !any_lo : !any_lr) nxt = 1;
                end
                4: if (!f_near) nxt = 3;
                5: begin
                    if (!f_oc1) nxt = 1;
                    else if (c_pd == L_OVD && any_lo) nxt = 4;
                end
                default: nxt = 0;
            endcase
            c_ovc = bump(k_ovc, tick, c_ovc, L_OVC);
            c_ovd = bump(k_ovd, tick, c_ovd, L_OVD);
            c_oc1 = bump(k_oc,  tick, c_oc1, L_OC1);
            c_oc2 = bump(k_oc,  tick, c_oc2, L_OC2);
            c_pd  = bump(k_pd,  tick, c_pd,  L_OVD);
            m_state = nxt;
        end
    end

    function automatic string tag_of(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R7";
            4: return "R8";
            default: return "R10";
        endcase
    endfunction

    // per-cycle comparison against the reference, away from the clock edge
    always @(negedge clk) begin
        if (chk_on) begin
            logic e_chg, e_dsg, e_pd;
            string tg;
            e_dsg = (m_state == 1) || (m_state == 2);
            e_pd  = (m_state == 4);
            e_chg = (m_state != 2) && !(!zero_allow && f_zinh);
            tg = (!zero_allow && f_zinh) ? "R14" : tag_of(m_state);
            n_checks++;
            if (int'(mode_code) != m_state || chg_en !== e_chg ||
                dsg_en !== e_dsg || pwr_down_req !== e_pd) begin
                n_fail++;
                $display("FAIL %s t=%0t mode/chg/dsg/pd actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
                         tg, $time, mode_code, chg_en, dsg_en, pwr_down_req,
                         m_state, e_chg, e_dsg, e_pd);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_mode(input int exp, input string tg);
        n_checks++;
        if (int'(mode_code) != exp) begin
            n_fail++;
            $display("FAIL %s mode actual %0d expected %0d", tg, mode_code, exp);
        end
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string nm, input string tg);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %b expected %b", tg, nm, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        #1;
        tick = slow_tick ? ~tick : 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset with load on the sense node keeps START
        sense_mv = 500;
        run(2);
        chk_on = 1'b1;
        rst_n = 1'b1;
        run(3);
        expect_mode(0, "R1");
        expect_bit(dsg_en, 1'b0, "dsg_en", "R1");
        expect_bit(chg_en, 1'b1, "chg_en", "R1");
        expect_bit(pwr_down_req, 1'b0, "pwr_down_req", "R1");
        sense_mv = 0;
        run(1);
        expect_mode(1, "R2");
        expect_bit(dsg_en, 1'b1, "dsg_en", "R2");

        // R3: short glitch does not trip, a held level does
        cell0_mv = 4400; run(2);
        cell0_mv = 3700; run(3);
        expect_mode(1, "R3");
        cell1_mv = 4400; run(4);
        expect_mode(1, "R3");
        run(1);
        expect_mode(2, "R3");
        expect_bit(chg_en, 1'b0, "chg_en", "R3");

        // R6 then R4
        cell1_mv = 3900; sense_mv = -1000; run(3);
        expect_mode(2, "R6");
        sense_mv = 0; run(1);
        expect_mode(1, "R4");

        // R5: release by load
        cell0_mv = 4400; run(5);
        expect_mode(2, "R3");
        cell0_mv = 4200; run(2);
        expect_mode(2, "R5");
        sense_mv = 300; run(1);
        expect_mode(1, "R5");
        sense_mv = 0; cell0_mv = 3700; run(2);

        // R12: overcurrent inhibited while a cell is high
        cell0_mv = 4400; sense_mv = 300; run(5);
        expect_mode(2, "R12");
        cell0_mv = 3700; sense_mv = 0; run(1);
        expect_mode(1, "R4");

        // R10: level 1 overcurrent and auto-release
        sense_mv = 300; run(3);
        expect_mode(1, "R10");
        run(1);
        expect_mode(5, "R10");
        expect_bit(dsg_en, 1'b0, "dsg_en", "R10");
        sense_mv = 0; run(1);
        expect_mode(1, "R10");

        // R11: level 2 trips ahead of level 1
        sense_mv = 1500; run(2);
        expect_mode(5, "R11");
        sense_mv = 0; run(1);
        expect_mode(1, "R11");

        // R2 priority and R13: overcurrent wins, then power-down
        cell0_mv = 2000; sense_mv = 500; run(4);
        expect_mode(5, "R2");
        run(7);
        expect_mode(4, "R13");
        expect_bit(pwr_down_req, 1'b1, "pwr_down_req", "R13");
        run(1);
        expect_mode(3, "R8");
        sense_mv = 6000; run(1);
        expect_mode(4, "R8");
        sense_mv = -1000; cell0_mv = 2500; run(2);
        expect_mode(1, "R9");
        sense_mv = 0; cell0_mv = 3700; run(2);

        // R7 and R9 without charger
        cell1_mv = 2000; run(6);
        expect_mode(1, "R7");
        run(1);
        expect_mode(3, "R7");
        expect_bit(chg_en, 1'b1, "chg_en", "R7");
        cell1_mv = 2500; run(3);
        expect_mode(3, "R9");
        cell1_mv = 3100; run(1);
        expect_mode(1, "R9");

        // R3 with a half-rate strobe
        slow_tick = 1'b1;
        cell0_mv = 4400; run(12);
        cell0_mv = 3700; sense_mv = 0; run(3);
        slow_tick = 1'b0;
        run(2);

        // R14: near-zero pack
        zero_allow = 1'b0; cell0_mv = 100; cell1_mv = 100;
        do_reset();
        expect_bit(chg_en, 1'b0, "chg_en", "R14");
        run(1);
        expect_bit(chg_en, 1'b0, "chg_en", "R14");
        zero_allow = 1'b1;
        do_reset();
        expect_bit(chg_en, 1'b1, "chg_en", "R14");
        run(8);
        cell0_mv = 3700; cell1_mv = 3700;
        run(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule